// File: doc/BRIEF.md
# One-Wait-State Ready Generator

This block stretches a bus cycle by exactly one clock when the addressed device cannot keep up with full-speed operation. At the start of every bus cycle the address-latch strobe clears a single toggle bit, which leaves the ready output asserted. A selected slow device pulls its device-ready line low. If that line is low on the first rising clock edge after the strobe (the edge that ends T2), the toggle bit flips and ready drops for one clock. On the following edge it flips back and ready returns, so the cycle can complete.

Once those two edges have passed, a small slot counter stops any further toggling. The device-ready line is then ignored until the next address-latch strobe. The ready output is meant to feed the processor's ready synchronizer. Address decoding and waits longer than one clock are left to other logic.

Top module: `one_wait_gen`

## Requirements
- R1: While `rst_n` is low, and after reset until the first `ale` strobe, `rdy_out` is 1 whatever `dev_ready` does.
- R2: A rising clock edge that samples `ale`=1 clears the wait state, so `rdy_out` is 1 in the following clock.
- R3: If `dev_ready`=1 on the first edge after the `ale` edge, `rdy_out` stays 1 for the whole bus cycle.
- R4: If `dev_ready`=0 on the first edge after the `ale` edge, `rdy_out` is 0 during exactly the next clock.
- R5: The second edge after the `ale` edge always restores `rdy_out` to 1, whatever the level of `dev_ready`.
- R6: From the third edge after the `ale` edge until the next `ale` strobe, `dev_ready` has no effect and `rdy_out` stays 1.
- R7: The level of `dev_ready` on the edge that samples `ale` has no effect on the cycle.
- R8: An `ale` strobe that arrives while a wait is in progress ends the wait and starts a new cycle.
- R9: `rdy_out` is never 0 for two clocks in a row, so each bus cycle takes at most one extra clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock. State changes on the rising edge. |
| rst_n | input | 1 | Asynchronous reset, active low. |
| ale | input | 1 | Address-latch strobe, active high, one clock per bus cycle. |
| dev_ready | input | 1 | Ready line from the selected device. 0 requests one wait state. |
| rdy_out | output | 1 | Ready to the synchronizer. 0 inserts a wait state. |

## Verification
A toggle bit stuck in the wrong state shows at `rdy_out` within one clock. It appears either as a missing wait in a slow cycle or as a second consecutive low clock. A slot counter that fails to saturate lets `dev_ready` noise late in the cycle pull `rdy_out` low, two or more clocks after the strobe. A wrong clear priority appears as a low `rdy_out` in the clock right after `ale`. The bench measures each of these as a count of low-ready clocks per cycle and compares it with the expected count.

// File: rtl/wsg_pkg.sv
package wsg_pkg;

  localparam int SLOT_W = 2;

  // Position of the next rising edge inside the bus cycle, counted from the
  // edge that sampled the address-latch strobe.
  typedef enum logic [SLOT_W-1:0] {
    SLOT_T2   = 2'd0,
    SLOT_T3   = 2'd1,
    SLOT_DONE = 2'd2
  } slot_t;

  // Advance one edge and hold once the toggle window has passed.
  function automatic slot_t next_slot(input slot_t cur);
    case (cur)
      SLOT_T2: next_slot = SLOT_T3;
      default: next_slot = SLOT_DONE;
    endcase
  endfunction

  // Whether the toggle bit should flip on this edge.
  // The first slot flips only when the device asks for a wait.
  // The second slot flips back only if a wait was entered.
  function automatic logic want_toggle(input slot_t cur,
                                       input logic  dev_rdy,
                                       input logic  waiting);
    case (cur)
      SLOT_T2: want_toggle = !dev_rdy;
      SLOT_T3: want_toggle = waiting;
      default: want_toggle = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/wsg_slot_counter.sv
module wsg_slot_counter
  import wsg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  restart,
  output slot_t slot
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       slot <= SLOT_DONE;
    else if (restart) slot <= SLOT_T2;
    else              slot <= next_slot(slot);
  end

  // R6: the counter must never leave its three legal positions.
  assert_slot_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    slot inside {SLOT_T2, SLOT_T3, SLOT_DONE});

  // R6: with no strobe, the done position is held.
  assert_slot_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && slot == SLOT_DONE) |=> slot == SLOT_DONE);

endmodule

// File: rtl/wsg_toggle_cell.sv
module wsg_toggle_cell #(
  parameter logic INIT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic toggle,
  output logic q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= INIT;
    else if (clear)  q <= INIT;
    else if (toggle) q <= ~q;
  end

  // R8: the clear takes priority over a pending toggle.
  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> q == INIT);

endmodule

// File: rtl/one_wait_gen.sv
module one_wait_gen
  import wsg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ale,
  input  logic dev_ready,
  output logic rdy_out
);

  slot_t slot;
  logic  wait_q;
  logic  toggle_req;
  logic  at_t2_edge;
  logic  at_t3_edge;
  logic  window_closed;

  wsg_slot_counter u_slot (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (ale),
    .slot    (slot)
  );

  assign at_t2_edge    = (slot == SLOT_T2);
  assign at_t3_edge    = (slot == SLOT_T3);
  assign window_closed = (slot == SLOT_DONE);
  assign toggle_req    = !ale && want_toggle(slot, dev_ready, wait_q);

  wsg_toggle_cell #(.INIT(1'b0)) u_wait (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (ale),
    .toggle (toggle_req),
    .q      (wait_q)
  );

  assign rdy_out = ~wait_q;

  assert_ale_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> rdy_out);

  assert_fast_no_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale && at_t2_edge && dev_ready) |=> rdy_out);

  assert_slow_one_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale && at_t2_edge && !dev_ready) |=> !rdy_out);

  assert_restore_R5: assert property (@(posedge clk) disable iff (!rst_n)
    at_t3_edge |=> rdy_out);

  assert_ignore_late_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale && window_closed) |=> rdy_out);

  assert_single_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_out |=> rdy_out);

endmodule

// File: tb/one_wait_gen_tb.sv
module one_wait_gen_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ale = 1'b0;
  logic dev_ready = 1'b1;
  logic rdy_out;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  one_wait_gen u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ale       (ale),
    .dev_ready (dev_ready),
    .rdy_out   (rdy_out)
  );

  // Each entry: {slow, noise[3:0]}. The noise is driven on dev_ready after the
  // T2 edge and must never produce a wait.
  localparam int NVEC = 8;
  localparam logic [4:0] VEC [NVEC] = '{
    5'b0_1111, 5'b1_1111, 5'b1_0000, 5'b0_0000,
    5'b1_0101, 5'b0_1010, 5'b1_1001, 5'b0_0110
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic run_cycle(input logic slow, input logic [3:0] noise,
                           input logic rdy_at_ale);
    int lows = 0;
    @(negedge clk); ale = 1'b1; dev_ready = rdy_at_ale;
    @(negedge clk); ale = 1'b0; dev_ready = ~slow;
    @(negedge clk);
    if (slow) check("R4", rdy_out, 1'b0);
    else      check("R3", rdy_out, 1'b1);
    if (!rdy_out) lows++;
    dev_ready = noise[0];
    @(negedge clk);
    check("R5", rdy_out, 1'b1);
    if (!rdy_out) lows++;
    dev_ready = noise[1];
    for (int k = 2; k < 5; k++) begin
      @(negedge clk);
      check("R6", rdy_out, 1'b1);
      if (!rdy_out) lows++;
      dev_ready = (k < 4) ? noise[k] : 1'b0;
    end
    check("R9", logic'(lows == int'(slow)), 1'b1);
  endtask

  initial begin
    // R1: reset state
    #1;
    check("R1", rdy_out, 1'b1);
    @(negedge clk); rst_n = 1'b1; dev_ready = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check("R1", rdy_out, 1'b1);
    end

    // Table walk: R3, R4, R5, R6, R9
    for (int i = 0; i < NVEC; i++)
      run_cycle(VEC[i][4], VEC[i][3:0], 1'b1);

    // R7: a low dev_ready only on the ale edge does not cause a wait
    run_cycle(1'b0, 4'b0000, 1'b0);
    // R2: the strobe clears the wait and ready is high in the next clock
    @(negedge clk); ale = 1'b1; dev_ready = 1'b0;
    @(negedge clk); ale = 1'b0; dev_ready = 1'b1;
    check("R2", rdy_out, 1'b1);
    check("R7", rdy_out, 1'b1);

    // R8: a strobe during a wait ends it and starts a fresh cycle
    @(negedge clk); ale = 1'b1; dev_ready = 1'b1;
    @(negedge clk); ale = 1'b0; dev_ready = 1'b0;
    @(negedge clk);
    check("R4", rdy_out, 1'b0);
    ale = 1'b1;
    @(negedge clk);
    check("R8", rdy_out, 1'b1);
    ale = 1'b0; dev_ready = 1'b0;
    @(negedge clk);
    check("R8", rdy_out, 1'b0);
    dev_ready = 1'b1;
    @(negedge clk);
    check("R9", rdy_out, 1'b1);

    // R1: reset in the middle of a wait restores ready at once
    @(negedge clk); ale = 1'b1;
    @(negedge clk); ale = 1'b0; dev_ready = 1'b0;
    @(negedge clk);
    check("R4", rdy_out, 1'b0);
    rst_n = 1'b0;
    #1;
    check("R1", rdy_out, 1'b1);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1", rdy_out, 1'b1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog R1 actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule